// File: doc/BRIEF.md
# Three-Pin General-Purpose Output Selector with Tune-Complete Interrupt

This block decides, for each of three general-purpose pins, what value is driven and whether the driver is enabled. Each pin has its own 2-bit mode field. The field can park the pin in high-Z, force it low or high, or hand it to a function that belongs to that pin. Pin 2's function is an active-low interrupt pulse raised when a seek/tune operation finishes. Pin 3's function repeats the stereo indicator flag. Pin 1 has no function, so its function code leaves it in high-Z.

A separate serial-audio enable input takes priority over all three mode fields. While it is set, every output enable is released so that an audio serialiser elsewhere in the chip can use the pins.

The chip-enable input affects only the function modes. With chip enable low, any pin in function mode goes to high-Z and any interrupt pulse in progress is dropped. The constant low, high and high-Z modes keep working no matter what chip enable does.

Top module: `gpio_mux_top`

## Requirements
- R1: After synchronous reset, no interrupt pulse is active. Pin 2 in function mode, with chip enable high, drives high.
- R2: Mode code 2'b00 deasserts the pin's output enable.
- R3: Mode code 2'b10 drives the pin low and mode code 2'b11 drives it high. In both cases the output enable is asserted.
- R4: The constant modes (2'b00, 2'b10, 2'b11) give the same pin result whether chip enable is high or low.
- R5: Mode code 2'b01 on pin 1 deasserts that pin's output enable.
- R6: Pin 2 in mode 2'b01 with chip enable high drives high while idle. A rising edge of `tune_done` that is sampled at clock edge E drives it low from E until clock edge E+PULSE_CYCLES, which is PULSE_CYCLES clocks.
- R7: A rising edge of `tune_done` starts no pulse while `irq_en` is low. Any clock edge at which `irq_en` is low ends a pulse that is running.
- R8: A new rising edge of `tune_done` during a pulse restarts the full PULSE_CYCLES low time from that edge.
- R9: Pin 3 in mode 2'b01 with chip enable high drives the level of `stereo`, and its output enable is asserted.
- R10: With chip enable low, a pin in mode 2'b01 has its output enable deasserted. Any clock edge at which chip enable is low cancels a pending interrupt pulse.
- R11: While `audio_en` is high, all three output enables are deasserted, whatever the mode fields say.
- R12: Only a rising edge of `tune_done` starts a pulse. Holding `tune_done` high does not start another one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| audio_en | input | 1 | Hands all pins to the serial-audio block |
| mode_p1 | input | 2 | Mode field for pin 1 |
| mode_p2 | input | 2 | Mode field for pin 2 |
| mode_p3 | input | 2 | Mode field for pin 3 |
| irq_en | input | 1 | Allows the tune-complete interrupt |
| tune_done | input | 1 | Seek/tune-complete status; its rising edge is the event |
| stereo | input | 1 | Stereo indicator flag |
| chip_en | input | 1 | Chip enable; gates only the function modes |
| pin_out | output | 3 | Drive value per pin, bit 0 is pin 1 |
| pin_oe | output | 3 | Output enable per pin, bit 0 is pin 1 |

## Verification
The bound checker holds several rules on every cycle. It checks the audio release of all enables, the high-Z result of codes 00 and pin 1's function code, the constant-high drive, the stereo passthrough and the chip-enable shutoff of function modes. It also checks that pin 2 in function mode always shows the inverse of the pulse state, that a pulse begins only after a sampled enabled event, and that a low enable or chip enable clears the pulse on the next edge. Only the bench's scenarios can show the exact pulse length, the full restart on a second edge and the refusal to re-fire on a held level.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int NUM_PINS = 3;

    typedef enum logic [1:0] {
        PM_HIZ  = 2'b00,
        PM_FUNC = 2'b01,
        PM_LOW  = 2'b10,
        PM_HIGH = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        FK_NONE   = 2'd0,
        FK_IRQ    = 2'd1,
        FK_STEREO = 2'd2
    } func_kind_e;

    typedef struct packed {
        logic val;
        logic oe;
    } pin_drive_t;

    localparam pin_drive_t DRIVE_OFF = '{val: 1'b0, oe: 1'b0};

    function automatic func_kind_e kind_of(input int idx);
        case (idx)
            1:       kind_of = FK_IRQ;
            2:       kind_of = FK_STEREO;
            default: kind_of = FK_NONE;
        endcase
    endfunction

    function automatic pin_drive_t const_drive(input logic level);
        const_drive.val = level;
        const_drive.oe  = 1'b1;
    endfunction

endpackage

// File: rtl/gpio_irq_pulse.sv
module gpio_irq_pulse #(
    parameter int PULSE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic irq_en,
    input  logic chip_en,
    input  logic tune_done,
    output logic irq_active
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic          done_q;
    logic [CW-1:0] remain;
    logic          edge_seen;

    assign edge_seen = tune_done & ~done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            remain <= '0;
        end else begin
            done_q <= tune_done;
            if (!chip_en || !irq_en) begin
                remain <= '0;
            end else if (edge_seen) begin
                remain <= LOAD;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    assign irq_active = (remain != '0);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_mux_pkg::*;
#(
    parameter func_kind_e KIND = FK_NONE
) (
    input  pin_mode_e  mode,
    input  logic       func_val,
    input  logic       chip_en,
    input  logic       audio_en,
    output pin_drive_t drive
);
    always_comb begin
        drive = DRIVE_OFF;
        if (!audio_en) begin
            case (mode)
                PM_LOW:  drive = const_drive(1'b0);
                PM_HIGH: drive = const_drive(1'b1);
                PM_FUNC: begin
                    if (KIND != FK_NONE && chip_en) begin
                        drive = const_drive(func_val);
                    end
                end
                default: drive = DRIVE_OFF;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mux_top.sv
module gpio_mux_top
    import gpio_mux_pkg::*;
#(
    parameter int PULSE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       audio_en,
    input  logic [1:0] mode_p1,
    input  logic [1:0] mode_p2,
    input  logic [1:0] mode_p3,
    input  logic       irq_en,
    input  logic       tune_done,
    input  logic       stereo,
    input  logic       chip_en,
    output logic [2:0] pin_out,
    output logic [2:0] pin_oe
);
    logic       irq_active;
    pin_mode_e  modes   [NUM_PINS];
    logic       func_src[NUM_PINS];
    pin_drive_t drives  [NUM_PINS];

    assign modes[0] = pin_mode_e'(mode_p1);
    assign modes[1] = pin_mode_e'(mode_p2);
    assign modes[2] = pin_mode_e'(mode_p3);

    gpio_irq_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk        (clk),
        .rst        (rst),
        .irq_en     (irq_en),
        .chip_en    (chip_en),
        .tune_done  (tune_done),
        .irq_active (irq_active)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam func_kind_e K = kind_of(g);
        if (K == FK_IRQ) begin : g_irq
            assign func_src[g] = ~irq_active;
        end else if (K == FK_STEREO) begin : g_st
            assign func_src[g] = stereo;
        end else begin : g_none
            assign func_src[g] = 1'b0;
        end

        gpio_pin_cell #(.KIND(K)) u_cell (
            .mode     (modes[g]),
            .func_val (func_src[g]),
            .chip_en  (chip_en),
            .audio_en (audio_en),
            .drive    (drives[g])
        );

        assign pin_out[g] = drives[g].val;
        assign pin_oe[g]  = drives[g].oe;
    end
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic       audio_en,
    input logic [1:0] mode_p1,
    input logic [1:0] mode_p2,
    input logic [1:0] mode_p3,
    input logic       irq_en,
    input logic       tune_done,
    input logic       stereo,
    input logic       chip_en,
    input logic       irq_active,
    input logic [2:0] pin_out,
    input logic [2:0] pin_oe
);
    AST_AUDIO_RELEASE: assert property (@(posedge clk) disable iff (rst)
        audio_en |-> pin_oe == 3'b000); // R11

    AST_HIZ_CODE: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && mode_p3 == 2'b00) |-> !pin_oe[2]); // R2

    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && mode_p2 == 2'b11) |-> (pin_oe[1] && pin_out[1])); // R3

    AST_PIN1_NOFUNC: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && mode_p1 == 2'b01) |-> !pin_oe[0]); // R5

    AST_STEREO_PASS: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && chip_en && mode_p3 == 2'b01) |-> (pin_oe[2] && pin_out[2] == stereo)); // R9

    AST_FUNC_OFF: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && !chip_en && mode_p2 == 2'b01) |-> !pin_oe[1]); // R10

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!audio_en && chip_en && mode_p2 == 2'b01) |-> (pin_oe[1] && pin_out[1] == !irq_active)); // R6

    AST_IRQ_START: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_active) |-> ($past(tune_done) && $past(irq_en) && $past(chip_en))); // R7

    AST_IRQ_CANCEL: assert property (@(posedge clk) disable iff (rst)
        (!chip_en || !irq_en) |=> !irq_active); // R10
endmodule

bind gpio_mux_top gpio_mux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .audio_en   (audio_en),
    .mode_p1    (mode_p1),
    .mode_p2    (mode_p2),
    .mode_p3    (mode_p3),
    .irq_en     (irq_en),
    .tune_done  (tune_done),
    .stereo     (stereo),
    .chip_en    (chip_en),
    .irq_active (irq_active),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
);

// File: tb/gpio_mux_top_test.sv
module gpio_mux_top_test;
    localparam int P = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       audio_en;
    logic [1:0] mode_p1, mode_p2, mode_p3;
    logic       irq_en, tune_done, stereo, chip_en;
    logic [2:0] pin_out, pin_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    gpio_mux_top #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst(rst), .audio_en(audio_en),
        .mode_p1(mode_p1), .mode_p2(mode_p2), .mode_p3(mode_p3),
        .irq_en(irq_en), .tune_done(tune_done), .stereo(stereo),
        .chip_en(chip_en), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    // pin 2 value and enable as {oe, val}
    task automatic chk_p2(input string req, input logic oe, input logic val);
        chk(req, {4'b0, pin_oe[1], pin_out[1]}, {4'b0, oe, val});
    endtask

    task automatic defaults();
        audio_en = 0; mode_p1 = 2'b00; mode_p2 = 2'b01; mode_p3 = 2'b00;
        irq_en = 1; tune_done = 0; stereo = 0; chip_en = 1;
    endtask

    task automatic t_reset();
        defaults();
        rst = 1;
        repeat (3) next();
        chk_p2("R1 reset idle", 1'b1, 1'b1);
        rst = 0;
        next();
        chk_p2("R1 after release", 1'b1, 1'b1);
    endtask

    task automatic t_const();
        defaults();
        mode_p1 = 2'b10; mode_p2 = 2'b11; mode_p3 = 2'b00;
        settle();
        chk("R3 R2 const", {pin_oe, pin_out}, {3'b011, 3'b010});
        mode_p1 = 2'b11; mode_p2 = 2'b10; mode_p3 = 2'b11;
        settle();
        chk("R3 const swap", {pin_oe, pin_out}, {3'b111, 3'b101});
        chip_en = 0;
        next();
        chk("R4 chip off const", {pin_oe, pin_out}, {3'b111, 3'b101});
        mode_p1 = 2'b00; mode_p2 = 2'b00; mode_p3 = 2'b10;
        settle();
        chk("R4 R2 chip off hiz", {pin_oe, pin_out}, {3'b100, 3'b000});
        chip_en = 1;
    endtask

    task automatic t_pin1_func();
        defaults();
        mode_p1 = 2'b01;
        settle();
        chk("R5 pin1 func", {5'b0, pin_oe[0]}, 6'b0);
    endtask

    task automatic t_pulse();
        defaults();
        next();
        chk_p2("R6 idle high", 1'b1, 1'b1);
        tune_done = 1;
        next();
        for (int i = 0; i < P; i++) begin
            chk_p2($sformatf("R6 low %0d", i), 1'b1, 1'b0);
            next();
        end
        chk_p2("R6 end high", 1'b1, 1'b1);
        repeat (P + 2) next();
        chk_p2("R12 held level", 1'b1, 1'b1);
        tune_done = 0;
        next();
    endtask

    task automatic t_gate();
        defaults();
        irq_en = 0;
        next();
        tune_done = 1;
        next();
        chk_p2("R7 disabled edge", 1'b1, 1'b1);
        tune_done = 0; irq_en = 1;
        next();
        tune_done = 1;
        next();
        chk_p2("R7 pulse started", 1'b1, 1'b0);
        irq_en = 0;
        next();
        chk_p2("R7 cancelled", 1'b1, 1'b1);
        tune_done = 0; irq_en = 1;
        next();
        chk_p2("R7 stays idle", 1'b1, 1'b1);
    endtask

    task automatic t_retrigger();
        defaults();
        next();
        tune_done = 1;
        next();
        tune_done = 0;
        next();
        tune_done = 1;
        next();
        for (int i = 0; i < P; i++) begin
            chk_p2($sformatf("R8 restart low %0d", i), 1'b1, 1'b0);
            next();
        end
        chk_p2("R8 restart end", 1'b1, 1'b1);
        tune_done = 0;
        next();
    endtask

    task automatic t_stereo();
        defaults();
        mode_p3 = 2'b01; stereo = 1;
        settle();
        chk("R9 stereo on", {4'b0, pin_oe[2], pin_out[2]}, 6'b000011);
        stereo = 0;
        settle();
        chk("R9 stereo off", {4'b0, pin_oe[2], pin_out[2]}, 6'b000010);
    endtask

    task automatic t_chip_off();
        defaults();
        mode_p3 = 2'b01; stereo = 1;
        next();
        tune_done = 1;
        next();
        chk_p2("R10 pulse running", 1'b1, 1'b0);
        chip_en = 0;
        settle();
        chk("R10 func hiz", {4'b0, pin_oe[2], pin_oe[1]}, 6'b0);
        next();
        chip_en = 1;
        settle();
        chk_p2("R10 pulse cancelled", 1'b1, 1'b1);
        tune_done = 0;
        next();
    endtask

    task automatic t_audio();
        defaults();
        mode_p1 = 2'b11; mode_p2 = 2'b10; mode_p3 = 2'b01; stereo = 1;
        audio_en = 1;
        next();
        chk("R11 audio release", {3'b0, pin_oe}, 6'b0);
        audio_en = 0;
        settle();
        chk("R11 audio back", {3'b0, pin_oe}, 6'b000111);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_const();
                t_pin1_func();
                t_pulse();
                t_gate();
                t_retrigger();
                t_stereo();
                t_chip_off();
                t_audio();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule